// File: doc/BRIEF.md
# Release-on-Register-Access Bus Interrupter

This block gathers event pulses from the rest of an interface controller and turns them into one request on a seven-line, active-low, prioritised interrupt bus. Software chooses the line with a 3-bit level register. Writing level 0 takes the block off the interrupt bus entirely. Each event sets a sticky bit in a status word, and software can poll that word at any time. The request stays asserted while any status bit is set.

When the bus master runs an acknowledge cycle, the daisy-chain input falls and the acknowledged level is presented on a 3-bit field. If that level equals the configured level and a request is pending, the block claims the cycle. It drives an 8-bit vector and asserts its data-acknowledge. Otherwise it passes the chain on through its daisy-chain output.

Two vectors are programmable: a normal one and an error one. The error vector is returned whenever an error-class source is pending. The acknowledge cycle does not clear the request. Software releases the line by writing ones to the status bits it has serviced.

Top module: `vme_rora_irq`

## Requirements
- R1: After reset, the status word, level and both vectors are zero. All seven request lines are high. Daisy-chain output and data-acknowledge are high, and the vector output enable is low.
- R2: A one on event input bit i sets status bit i at the next clock edge. The bit stays set until it is cleared, and this holds through any number of acknowledge cycles. Bit assignment: 0 data in, 1 data out, 2 end received, 3 handshake error, 4 bus error, 5 transfer finished.
- R3: With level L in 1..7 and a nonzero status word, request line L (irq_n_o bit L-1) is low and the other six lines are high.
- R4: With level 0, all seven request lines stay high whatever the status word holds.
- R5: A clear write drops each status bit whose clear-data bit is one and leaves the other bits unchanged. If an event and a clear hit the same bit in one cycle, the bit ends up set.
- R6: If the daisy-chain input is low, the acknowledged level equals a nonzero configured level and a request is pending, the block responds one clock later. It drives data-acknowledge low and the vector enable high, and it keeps the daisy-chain output high. With no error bit pending, the vector is the normal vector.
- R7: When status bit 3 or bit 4 is set at the moment the acknowledge is claimed, the vector driven is the error vector.
- R8: If the acknowledged level differs from the configured level, or nothing is pending, or the level is 0, the daisy-chain output goes low one clock after the input falls. Data-acknowledge stays high and the vector enable stays low.
- R9: One clock after the daisy-chain input returns high, data-acknowledge and the daisy-chain output are both high and the vector enable is low.
- R10: Once the block is responding or passing, it keeps that choice until the daisy-chain input rises, even if the status word is cleared meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Event pulses, one per source |
| cfg_we | input | 1 | Level register write strobe |
| cfg_level | input | 3 | Request level to write (0 disables) |
| vec_we | input | 1 | Vector register write strobe |
| vec_sel | input | 1 | 0 writes the normal vector, 1 writes the error vector |
| vec_data | input | 8 | Vector value to write |
| clr_we | input | 1 | Status clear write strobe |
| clr_data | input | 6 | Write-one-to-clear mask |
| status_o | output | 6 | Pollable status word |
| iackin_n | input | 1 | Daisy-chain acknowledge input, active low |
| iack_lvl | input | 3 | Level being acknowledged |
| irq_n_o | output | 7 | Request lines 1..7 (bit 0 is line 1), active low |
| iackout_n | output | 1 | Daisy-chain acknowledge output, active low |
| vdata_o | output | 8 | Vector byte |
| vdata_oe | output | 1 | Vector drive enable |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The acknowledge path is exercised at a matching level, a non-matching level, with nothing pending and with the block disabled. These cases tell claiming apart from passing the chain on. Acknowledges with only data sources pending and with a bus-error source pending show whether the vector is chosen by error class. Single-bit clears, a clear that collides with an event, and a clear issued in the middle of a claimed cycle separate the write-one-to-clear behaviour, the set-wins priority and the held decision. Level 7 and level 0 cover both ends of the line decoder.

// File: rtl/vme_irq_pkg.sv
package vme_irq_pkg;
   typedef enum logic [1:0] {
      ACK_IDLE = 2'd0,
      ACK_RESP = 2'd1,
      ACK_PASS = 2'd2
   } ack_state_t;
endpackage

// File: rtl/vme_irq_status.sv
module vme_irq_status #(
   parameter int NSRC = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_i,
   input  logic            clr_we,
   input  logic [NSRC-1:0] clr_data,
   output logic [NSRC-1:0] status_q
);
   logic [NSRC-1:0] keep_mask;

   // Set has priority over clear: the event term is ORed after masking.
   assign keep_mask = clr_we ? ~clr_data : {NSRC{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & keep_mask) | evt_i;
   end
endmodule

// File: rtl/vme_irq_lines.sv
module vme_irq_lines #(
   parameter int NLINES = 7,
   parameter int LVL_W  = 3
) (
   input  logic              pending,
   input  logic [LVL_W-1:0]  level,
   output logic [NLINES-1:0] irq_n
);
   for (genvar g = 0; g < NLINES; g++) begin : g_line
      localparam logic [LVL_W-1:0] MY_LVL = LVL_W'(g + 1);
      assign irq_n[g] = ~(pending && (level == MY_LVL));
   end
endmodule

// File: rtl/vme_iack_resp.sv
module vme_iack_resp
   import vme_irq_pkg::*;
#(
   parameter int LVL_W = 3,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iackin_n,
   input  logic [LVL_W-1:0] iack_lvl,
   input  logic [LVL_W-1:0] level,
   input  logic             pending,
   input  logic             err_pending,
   input  logic [VEC_W-1:0] vec_norm,
   input  logic [VEC_W-1:0] vec_err,
   output logic             iackout_n,
   output logic [VEC_W-1:0] vdata_o,
   output logic             vdata_oe,
   output logic             dtack_n
);
   ack_state_t       state_q, state_d;
   logic [VEC_W-1:0] vec_q, vec_d;
   logic             claim;

   assign claim = pending && (level != '0) && (iack_lvl == level);

   always_comb begin
      state_d = state_q;
      vec_d   = vec_q;
      if (iackin_n) begin
         state_d = ACK_IDLE;
      end else if (state_q == ACK_IDLE) begin
         if (claim) begin
            state_d = ACK_RESP;
            vec_d   = err_pending ? vec_err : vec_norm;
         end else begin
            state_d = ACK_PASS;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ACK_IDLE;
         vec_q   <= '0;
      end else begin
         state_q <= state_d;
         vec_q   <= vec_d;
      end
   end

   assign dtack_n   = (state_q != ACK_RESP);
   assign vdata_oe  = (state_q == ACK_RESP);
   assign iackout_n = (state_q != ACK_PASS);
   assign vdata_o   = vec_q;
endmodule

// File: rtl/vme_rora_irq.sv
module vme_rora_irq #(
   parameter int          NSRC     = 6,
   parameter int          NLINES   = 7,
   parameter int          LVL_W    = 3,
   parameter int          VEC_W    = 8,
   parameter logic [5:0]  ERR_MASK = 6'b01_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic              cfg_we,
   input  logic [LVL_W-1:0]  cfg_level,
   input  logic              vec_we,
   input  logic              vec_sel,
   input  logic [VEC_W-1:0]  vec_data,
   input  logic              clr_we,
   input  logic [NSRC-1:0]   clr_data,
   output logic [NSRC-1:0]   status_o,
   input  logic              iackin_n,
   input  logic [LVL_W-1:0]  iack_lvl,
   output logic [NLINES-1:0] irq_n_o,
   output logic              iackout_n,
   output logic [VEC_W-1:0]  vdata_o,
   output logic              vdata_oe,
   output logic              dtack_n
);
   localparam int MAX_LINES = (1 << LVL_W) - 1;

   if (NSRC < 1 || NSRC > 6) begin : g_bad_nsrc
      $error("NSRC must be 1..6 to fit the error mask");
   end
   if (NLINES != MAX_LINES) begin : g_bad_lines
      $error("NLINES must equal 2**LVL_W - 1");
   end

   logic [LVL_W-1:0] level_q;
   logic [VEC_W-1:0] vec_norm_q, vec_err_q;
   logic [NSRC-1:0]  status_q;
   logic             pending, err_pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q    <= '0;
         vec_norm_q <= '0;
         vec_err_q  <= '0;
      end else begin
         if (cfg_we) level_q <= cfg_level;
         if (vec_we && !vec_sel) vec_norm_q <= vec_data;
         if (vec_we &&  vec_sel) vec_err_q  <= vec_data;
      end
   end

   vme_irq_status #(.NSRC(NSRC)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .status_q (status_q)
   );

   assign pending     = |status_q;
   assign err_pending = |(status_q & ERR_MASK[NSRC-1:0]);
   assign status_o    = status_q;

   vme_irq_lines #(.NLINES(NLINES), .LVL_W(LVL_W)) u_lines (
      .pending (pending),
      .level   (level_q),
      .irq_n   (irq_n_o)
   );

   vme_iack_resp #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_iack (
      .clk         (clk),
      .rst_n       (rst_n),
      .iackin_n    (iackin_n),
      .iack_lvl    (iack_lvl),
      .level       (level_q),
      .pending     (pending),
      .err_pending (err_pending),
      .vec_norm    (vec_norm_q),
      .vec_err     (vec_err_q),
      .iackout_n   (iackout_n),
      .vdata_o     (vdata_o),
      .vdata_oe    (vdata_oe),
      .dtack_n     (dtack_n)
   );
endmodule

// File: rtl/vme_rora_irq_chk.sv
module vme_rora_irq_chk #(
   parameter int NSRC   = 6,
   parameter int NLINES = 7,
   parameter int LVL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   evt_i,
   input logic              clr_we,
   input logic [NSRC-1:0]   clr_data,
   input logic [NSRC-1:0]   status_o,
   input logic [LVL_W-1:0]  level_q,
   input logic              iackin_n,
   input logic [NLINES-1:0] irq_n_o,
   input logic              iackout_n,
   input logic              vdata_oe,
   input logic              dtack_n
);
   // R2
   sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((status_o & $past(status_o)) == $past(status_o)));

   // R5
   clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && evt_i == '0) |=> ((status_o & $past(clr_data)) == '0));

   // R3
   one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != '0 && status_o != '0) |-> ($countones(~irq_n_o) == 1));

   // R4
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q == '0) |-> (&irq_n_o));

   // R6
   claim_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_n |-> (vdata_oe && iackout_n));

   // R9
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iackin_n |=> (dtack_n && iackout_n && !vdata_oe));
endmodule

bind vme_rora_irq vme_rora_irq_chk #(.NSRC(NSRC), .NLINES(NLINES), .LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .clr_we    (clr_we),
   .clr_data  (clr_data),
   .status_o  (status_o),
   .level_q   (level_q),
   .iackin_n  (iackin_n),
   .irq_n_o   (irq_n_o),
   .iackout_n (iackout_n),
   .vdata_oe  (vdata_oe),
   .dtack_n   (dtack_n)
);

// File: tb/vme_rora_irq_tb.sv
module vme_rora_irq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt_i = '0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_level = '0;
   logic       vec_we = 1'b0;
   logic       vec_sel = 1'b0;
   logic [7:0] vec_data = '0;
   logic       clr_we = 1'b0;
   logic [5:0] clr_data = '0;
   logic [5:0] status_o;
   logic       iackin_n = 1'b1;
   logic [2:0] iack_lvl = '0;
   logic [6:0] irq_n_o;
   logic       iackout_n;
   logic [7:0] vdata_o;
   logic       vdata_oe;
   logic       dtack_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [7:0] VN = 8'h5A;
   localparam logic [7:0] VE = 8'hE1;

   always #5 clk = ~clk;

   vme_rora_irq dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .cfg_we(cfg_we), .cfg_level(cfg_level),
      .vec_we(vec_we), .vec_sel(vec_sel), .vec_data(vec_data),
      .clr_we(clr_we), .clr_data(clr_data), .status_o(status_o),
      .iackin_n(iackin_n), .iack_lvl(iack_lvl), .irq_n_o(irq_n_o),
      .iackout_n(iackout_n), .vdata_o(vdata_o), .vdata_oe(vdata_oe),
      .dtack_n(dtack_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_level(input logic [2:0] l);
      cfg_we = 1'b1; cfg_level = l; step(); cfg_we = 1'b0;
   endtask

   task automatic set_vec(input logic s, input logic [7:0] v);
      vec_we = 1'b1; vec_sel = s; vec_data = v; step(); vec_we = 1'b0;
   endtask

   task automatic pulse(input logic [5:0] m);
      evt_i = m; step(); evt_i = '0;
   endtask

   task automatic clear(input logic [5:0] m);
      clr_we = 1'b1; clr_data = m; step(); clr_we = 1'b0; clr_data = '0;
   endtask

   task automatic ack_begin(input logic [2:0] l);
      iack_lvl = l; iackin_n = 1'b0; step();
   endtask

   task automatic ack_end(input string req);
      iackin_n = 1'b1; step();
      check({req, " release dtack"}, 32'(dtack_n), 32'd1);
      check({req, " release iackout"}, 32'(iackout_n), 32'd1);
      check({req, " release oe"}, 32'(vdata_oe), 32'd0);
   endtask

   task automatic t_reset();
      check("R1 status", 32'(status_o), 32'h0);
      check("R1 irq", 32'(irq_n_o), 32'h7F);
      check("R1 iackout", 32'(iackout_n), 32'd1);
      check("R1 dtack", 32'(dtack_n), 32'd1);
      check("R1 oe", 32'(vdata_oe), 32'd0);
   endtask

   task automatic t_request();
      set_level(3'd3);
      pulse(6'b000001);
      check("R2 status set", 32'(status_o), 32'h01);
      check("R3 line 3", 32'(irq_n_o), 32'h7B);
   endtask

   task automatic t_ack_normal();
      ack_begin(3'd3);
      check("R6 dtack", 32'(dtack_n), 32'd0);
      check("R6 oe", 32'(vdata_oe), 32'd1);
      check("R6 vector", 32'(vdata_o), 32'(VN));
      check("R6 iackout held", 32'(iackout_n), 32'd1);
      ack_end("R9");
      check("R2 status kept after ack", 32'(status_o), 32'h01);
      check("R2 irq kept after ack", 32'(irq_n_o), 32'h7B);
   endtask

   task automatic t_mismatch();
      ack_begin(3'd5);
      check("R8 mismatch iackout", 32'(iackout_n), 32'd0);
      check("R8 mismatch dtack", 32'(dtack_n), 32'd1);
      check("R8 mismatch oe", 32'(vdata_oe), 32'd0);
      ack_end("R9");
   endtask

   task automatic t_error_vec();
      pulse(6'b010000);
      ack_begin(3'd3);
      check("R7 error vector", 32'(vdata_o), 32'(VE));
      check("R7 dtack", 32'(dtack_n), 32'd0);
      ack_end("R9");
   endtask

   task automatic t_clear();
      clear(6'b010000);
      check("R5 partial clear", 32'(status_o), 32'h01);
      check("R5 irq still low", 32'(irq_n_o), 32'h7B);
      clear(6'b000001);
      check("R5 full clear", 32'(status_o), 32'h00);
      check("R5 irq released", 32'(irq_n_o), 32'h7F);
   endtask

   task automatic t_nopend();
      ack_begin(3'd3);
      check("R8 nothing pending iackout", 32'(iackout_n), 32'd0);
      check("R8 nothing pending dtack", 32'(dtack_n), 32'd1);
      ack_end("R9");
   endtask

   task automatic t_set_wins();
      evt_i = 6'b000100; clr_we = 1'b1; clr_data = 6'b000100;
      step();
      evt_i = '0; clr_we = 1'b0; clr_data = '0;
      check("R5 set wins", 32'(status_o), 32'h04);
   endtask

   task automatic t_level7();
      set_level(3'd7);
      check("R3 line 7", 32'(irq_n_o), 32'h3F);
      ack_begin(3'd7);
      check("R6 level 7 claim", 32'(dtack_n), 32'd0);
      check("R6 level 7 vector", 32'(vdata_o), 32'(VN));
      ack_end("R9");
   endtask

   task automatic t_hold();
      ack_begin(3'd7);
      clear(6'b000100);
      check("R10 held dtack", 32'(dtack_n), 32'd0);
      check("R10 held vector", 32'(vdata_o), 32'(VN));
      ack_end("R9");
      check("R5 cleared in ack", 32'(status_o), 32'h00);
   endtask

   task automatic t_level0();
      pulse(6'b100000);
      set_level(3'd0);
      check("R4 lines quiet", 32'(irq_n_o), 32'h7F);
      ack_begin(3'd0);
      check("R8 disabled iackout", 32'(iackout_n), 32'd0);
      check("R8 disabled dtack", 32'(dtack_n), 32'd1);
      ack_end("R9");
      check("R2 status while disabled", 32'(status_o), 32'h20);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      set_vec(1'b0, VN);
      set_vec(1'b1, VE);
      t_request();
      t_ack_normal();
      t_mismatch();
      t_error_vec();
      t_clear();
      t_nopend();
      t_set_wins();
      t_level7();
      t_hold();
      t_level0();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule